// File: doc/BRIEF.md
# Serial Frame Address Filter

This block sits behind a bit deserializer and decides whether an incoming serial frame is addressed to this station. After a begin-of-frame strobe it gathers the leading address bits of the frame, one bit per cycle in which `bit_valid` is high. It then compares them against four 8-bit match registers and raises a held accept-or-reject verdict. A per-frame configuration bit selects an address length of 8 or 16 bits.

In 8-bit mode the four registers act as four independent comparators, and any hit accepts the frame. In 16-bit mode the registers pair up into two 16-bit match words. Slot 1 is the upper byte over slot 0, and slot 3 is the upper byte over slot 2. Only a full 16-bit equality with one of the two pairs accepts. A simple write port loads the registers. A frame that ends before its address is complete is rejected. Downstream logic samples `dec_accept` while `dec_valid` is high. The verdict stays put until the next frame begins.

Top module: `frame_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0 and all four match registers hold 0x00.
- R2: A cycle with `cfg_wr_en` high loads `cfg_wr_data` into the match register chosen by `cfg_wr_sel` (0 to 3). Frames that start later compare against the new value.
- R3: When `cfg_wide` is 0 at the begin-of-frame, the first 8 accepted bits form the address, least significant bit first. The frame is accepted if that byte equals any of the four registers.
- R4: When `cfg_wide` is 1 at the begin-of-frame, the first 16 accepted bits form the address, least significant bit first. The frame is accepted only if the address equals {slot1,slot0} or {slot3,slot2}. A byte-level match alone does not accept.
- R5: `dec_valid` is 0 while the address is being gathered. It rises in the cycle right after the cycle that presented the last address bit.
- R6: Once `dec_valid` is 1, it and `dec_accept` hold their values until the next begin-of-frame. Further bits and end-of-frame strobes have no effect on them.
- R7: A `sof` cycle clears `dec_valid` in the next cycle. A bit presented in the same cycle as `sof` is discarded.
- R8: An `eof` that arrives before the last address bit gives `dec_valid`=1 with `dec_accept`=0 in the next cycle.
- R9: The address length is captured at `sof`. Changing `cfg_wide` during the frame does not change how many bits are gathered or how they are compared.
- R10: Cycles with `bit_valid` low add no bit, whatever the value of `bit_data`.
- R11: `dec_accept` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Match register write strobe |
| cfg_wr_sel | input | 2 | Match register index |
| cfg_wr_data | input | 8 | Match register write data |
| cfg_wide | input | 1 | Address length select, 0 = 8 bits, 1 = 16 bits, sampled at `sof` |
| sof | input | 1 | Begin-of-frame strobe |
| eof | input | 1 | End-of-frame strobe |
| bit_valid | input | 1 | A received bit is present on `bit_data` |
| bit_data | input | 1 | Received bit value |
| dec_valid | output | 1 | Verdict available |
| dec_accept | output | 1 | Frame accepted (meaningful while `dec_valid` is 1) |

## Verification
The assertions watch the verdict's framing on every cycle. They check that:
- an accept never appears without a valid verdict;
- a new frame clears the verdict;
- a verdict, once valid, holds until the next frame;
- a verdict only appears after a bit or an end-of-frame;
- an early end always rejects.

Only the bench's scenarios can show that the right registers were compared, in the right byte order and bit order. The same goes for the exact cycle at which the verdict appears for each address length, the effect of register writes, and the fact that mode changes, idle gaps and bits coinciding with `sof` do not disturb the gathered address.

// File: rtl/faf_pkg.sv
package faf_pkg;

    // Address length selection, captured per frame.
    typedef enum logic {
        ALEN_NARROW = 1'b0,
        ALEN_WIDE   = 1'b1
    } alen_e;

    // Collector state.
    typedef enum logic {
        COL_IDLE = 1'b0,
        COL_ADDR = 1'b1
    } col_state_e;

    // Held frame verdict.
    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

    localparam verdict_t VERDICT_NONE   = '{valid: 1'b0, accept: 1'b0};
    localparam verdict_t VERDICT_REJECT = '{valid: 1'b1, accept: 1'b0};

    // Convert the raw mode pin into the length enum.
    function automatic alen_e decode_len(input logic wide);
        return wide ? ALEN_WIDE : ALEN_NARROW;
    endfunction

endpackage

// File: rtl/faf_match_regs.sv
module faf_match_regs #(
    parameter int unsigned SLOT_W    = 8,
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned SEL_W     = $clog2(NUM_SLOTS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   wr_sel,
    input  logic [SLOT_W-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][SLOT_W-1:0]   slots
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (wr_en) begin
            for (int unsigned i = 0; i < NUM_SLOTS; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    slots[i] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/faf_collector.sv
module faf_collector
    import faf_pkg::*;
#(
    parameter int unsigned SLOT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sof,
    input  logic                  eof,
    input  logic                  bit_valid,
    input  logic                  bit_data,
    input  alen_e                 len_sel,
    output logic [2*SLOT_W-1:0]   addr_next,
    output alen_e                 len_q,
    output logic                  last_bit,
    output logic                  early_end
);

    localparam int unsigned ADDR_W = 2 * SLOT_W;
    localparam int unsigned CNT_W  = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(SLOT_W - 1);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(ADDR_W - 1);

    col_state_e          state_q;
    logic [ADDR_W-1:0]   shreg_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    last_idx;
    logic                collecting;
    logic                take;

    // Bits enter at the top and walk down: first bit ends at the lowest
    // position of the address length in use.
    assign addr_next  = {bit_data, shreg_q[ADDR_W-1:1]};
    assign collecting = (state_q == COL_ADDR) && !sof;
    assign take       = collecting && bit_valid;
    assign last_idx   = (len_q == ALEN_WIDE) ? LAST_WIDE : LAST_NARROW;
    assign last_bit   = take && (cnt_q == last_idx);
    assign early_end  = collecting && eof && !last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= COL_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            len_q   <= ALEN_NARROW;
        end else if (sof) begin
            state_q <= COL_ADDR;
            shreg_q <= '0;
            cnt_q   <= '0;
            len_q   <= len_sel;
        end else if (state_q == COL_ADDR) begin
            if (take) begin
                shreg_q <= addr_next;
                cnt_q   <= cnt_q + CNT_W'(1);
            end
            if (last_bit || eof) begin
                state_q <= COL_IDLE;
            end
        end
    end

endmodule

// File: rtl/faf_compare.sv
module faf_compare
    import faf_pkg::*;
#(
    parameter int unsigned SLOT_W    = 8,
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slots,
    input  logic [2*SLOT_W-1:0]              addr,
    input  alen_e                            len_sel,
    output logic                             hit
);

    localparam int unsigned ADDR_W    = 2 * SLOT_W;
    localparam int unsigned NUM_PAIRS = NUM_SLOTS / 2;

    logic [NUM_SLOTS-1:0] narrow_hit;
    logic [NUM_PAIRS-1:0] wide_hit;

    // One byte comparator per slot; a short address sits in the top byte.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_narrow
        assign narrow_hit[g] = (addr[ADDR_W-1 -: SLOT_W] == slots[g]);
    end

    // Paired comparators: odd slot is the upper byte.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_wide
        assign wide_hit[p] = (addr == {slots[2*p+1], slots[2*p]});
    end

    assign hit = (len_sel == ALEN_WIDE) ? (|wide_hit) : (|narrow_hit);

endmodule

// File: rtl/frame_addr_filter.sv
module frame_addr_filter
    import faf_pkg::*;
#(
    parameter int unsigned SLOT_W    = 8,
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned SEL_W     = $clog2(NUM_SLOTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic [SEL_W-1:0]   cfg_wr_sel,
    input  logic [SLOT_W-1:0]  cfg_wr_data,
    input  logic               cfg_wide,
    input  logic               sof,
    input  logic               eof,
    input  logic               bit_valid,
    input  logic               bit_data,
    output logic               dec_valid,
    output logic               dec_accept
);

    localparam int unsigned ADDR_W = 2 * SLOT_W;

    logic [NUM_SLOTS-1:0][SLOT_W-1:0] slots;
    logic [ADDR_W-1:0]                addr_next;
    alen_e                            len_q;
    logic                             last_bit;
    logic                             early_end;
    logic                             hit;
    verdict_t                         verdict_q;

    faf_match_regs #(
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .slots   (slots)
    );

    faf_collector #(
        .SLOT_W (SLOT_W)
    ) u_collect (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .eof       (eof),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .len_sel   (decode_len(cfg_wide)),
        .addr_next (addr_next),
        .len_q     (len_q),
        .last_bit  (last_bit),
        .early_end (early_end)
    );

    faf_compare #(
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_cmp (
        .slots   (slots),
        .addr    (addr_next),
        .len_sel (len_q),
        .hit     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst || sof) begin
            verdict_q <= VERDICT_NONE;
        end else if (last_bit) begin
            verdict_q <= '{valid: 1'b1, accept: hit};
        end else if (early_end) begin
            verdict_q <= VERDICT_REJECT;
        end
    end

    assign dec_valid  = verdict_q.valid;
    assign dec_accept = verdict_q.accept;

endmodule

// File: rtl/faf_checker.sv
module faf_checker (
    input logic clk,
    input logic rst,
    input logic sof,
    input logic eof,
    input logic bit_valid,
    input logic dec_valid,
    input logic dec_accept
);

    // R1: verdict empty right after reset
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dec_valid && !dec_accept));

    // R11: no accept without a verdict
    p_accept_gated_r11: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_accept);

    // R7: new frame clears the verdict
    p_sof_clears_r7: assert property (@(posedge clk) disable iff (rst)
        sof |=> !dec_valid);

    // R6: verdict holds until next frame
    p_verdict_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !sof) |=> (dec_valid && $stable(dec_accept)));

    // R5: a verdict only follows a bit or an end strobe
    p_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) |-> ($past(bit_valid) || $past(eof)));

    // R8: an end with no bit alongside can only reject
    p_early_reject_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(dec_valid) && !$past(bit_valid)) |-> !dec_accept);

endmodule

bind frame_addr_filter faf_checker u_faf_checker (
    .clk        (clk),
    .rst        (rst),
    .sof        (sof),
    .eof        (eof),
    .bit_valid  (bit_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
);

// File: tb/test_frame_addr_filter.sv
module test_frame_addr_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_sel = '0;
    logic [7:0] cfg_wr_data = '0;
    logic       cfg_wide = 1'b0;
    logic       sof = 1'b0;
    logic       eof = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       dec_valid;
    logic       dec_accept;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] model_regs [4];

    logic  q_acc [$];
    int    q_cyc [$];
    string q_tag [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frame_addr_filter i_frame_addr_filter (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .cfg_wide    (cfg_wide),
        .sof         (sof),
        .eof         (eof),
        .bit_valid   (bit_valid),
        .bit_data    (bit_data),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept)
    );

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic model_hit(input logic [15:0] a, input logic wide);
        if (wide)
            return (a == {model_regs[1], model_regs[0]}) || (a == {model_regs[3], model_regs[2]});
        return (a[7:0] == model_regs[0]) || (a[7:0] == model_regs[1]) ||
               (a[7:0] == model_regs[2]) || (a[7:0] == model_regs[3]);
    endfunction

    // Monitor: pops one expected verdict at every rising dec_valid.
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            prev_v = 1'b0;
        end else begin
            if (dec_valid && !prev_v) begin
                if (q_acc.size() == 0) begin
                    check("R5 unexpected verdict", 1'b0, 1, 0);
                end else begin
                    logic  ea;
                    int    ec;
                    string et;
                    ea = q_acc.pop_front();
                    ec = q_cyc.pop_front();
                    et = q_tag.pop_front();
                    check({et, " accept"}, dec_accept == ea, int'(dec_accept), int'(ea));
                    check("R5 verdict cycle", cyc == ec, cyc, ec);
                end
            end
            prev_v = dec_valid;
        end
    end

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_regs[sel] = data;
    endtask

    // One frame; nbits bits are sent, early ends it with eof afterwards.
    task automatic frame(input logic [15:0] a, input logic wide, input int nbits,
                         input logic early, input logic gaps, input logic flip,
                         input logic sof_bit, input string tag);
        int   need;
        logic exp_acc;
        need    = wide ? 16 : 8;
        exp_acc = early ? 1'b0 : model_hit(a, wide);
        @(negedge clk);
        sof = 1'b1; cfg_wide = wide; eof = 1'b0;
        bit_valid = sof_bit; bit_data = 1'b1;
        @(negedge clk);
        sof = 1'b0; bit_valid = 1'b0;
        check("R7 cleared after sof", dec_valid == 1'b0, int'(dec_valid), 0);
        if (flip) cfg_wide = !wide;
        for (int i = 0; i < nbits; i++) begin
            bit_valid = 1'b1; bit_data = a[i];
            if (!early && i == need - 1) begin
                q_acc.push_back(exp_acc); q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
            end
            @(negedge clk);
            if (i < need - 1)
                check("R5 quiet while gathering", dec_valid == 1'b0, int'(dec_valid), 0);
            if (gaps) begin
                bit_valid = 1'b0; bit_data = !a[i];
                @(negedge clk);
            end
        end
        bit_valid = 1'b0;
        if (early) begin
            eof = 1'b1;
            q_acc.push_back(1'b0); q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
            @(negedge clk);
            eof = 1'b0;
        end
        check("R6 verdict held", dec_valid == 1'b1 && dec_accept == exp_acc,
              int'({dec_valid, dec_accept}), int'({1'b1, exp_acc}));
        for (int k = 0; k < 4; k++) begin
            bit_valid = 1'b1; bit_data = k[0]; eof = (k == 2);
            @(negedge clk);
            check("R6 verdict held", dec_valid == 1'b1 && dec_accept == exp_acc,
                  int'({dec_valid, dec_accept}), int'({1'b1, exp_acc}));
        end
        bit_valid = 1'b0; eof = 1'b0; cfg_wide = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1'b0, cyc, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) model_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset verdict", dec_valid == 1'b0 && dec_accept == 1'b0,
              int'({dec_valid, dec_accept}), 0);
        // R1: registers cleared, so address 0x00 matches
        frame(16'h0000, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R1 zero regs");

        // R2: load registers
        write_reg(2'd0, 8'h3C);
        write_reg(2'd1, 8'hA5);
        write_reg(2'd2, 8'h7E);
        write_reg(2'd3, 8'h01);

        // R3: narrow mode, every slot and a miss
        frame(16'h003C, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 slot0");
        frame(16'h00A5, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 slot1");
        frame(16'h007E, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 slot2");
        frame(16'h0001, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 slot3");
        frame(16'h0055, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 miss");
        frame(16'h0000, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 old value gone");

        // R4: wide mode, pairs, swapped and crossed bytes
        frame(16'hA53C, 1'b1, 16, 1'b0, 1'b0, 1'b0, 1'b0, "R4 pair01");
        frame(16'h017E, 1'b1, 16, 1'b0, 1'b0, 1'b0, 1'b0, "R4 pair23");
        frame(16'h3CA5, 1'b1, 16, 1'b0, 1'b0, 1'b0, 1'b0, "R4 swapped");
        frame(16'h013C, 1'b1, 16, 1'b0, 1'b0, 1'b0, 1'b0, "R4 crossed");
        frame(16'h003C, 1'b1, 16, 1'b0, 1'b0, 1'b0, 1'b0, "R4 byte only");

        // R10: idle gaps with toggling data
        frame(16'hA53C, 1'b1, 16, 1'b0, 1'b1, 1'b0, 1'b0, "R10 gaps wide");
        frame(16'h007E, 1'b0, 8, 1'b0, 1'b1, 1'b0, 1'b0, "R10 gaps narrow");

        // R8: early end
        frame(16'h003C, 1'b0, 5, 1'b1, 1'b0, 1'b0, 1'b0, "R8 short narrow");
        frame(16'h003C, 1'b1, 8, 1'b1, 1'b0, 1'b0, 1'b0, "R8 short wide");
        frame(16'h0000, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 empty");

        // R9: mode flips mid-frame
        frame(16'h007E, 1'b0, 8, 1'b0, 1'b0, 1'b1, 1'b0, "R9 narrow kept");
        frame(16'hA53C, 1'b1, 16, 1'b0, 1'b0, 1'b1, 1'b0, "R9 wide kept");

        // R7: bit alongside sof is dropped
        frame(16'h003C, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R7 sof bit dropped");

        // R2: rewrite a slot
        write_reg(2'd2, 8'h99);
        frame(16'h0099, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R2 new value");
        frame(16'h007E, 1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R2 old value");
        frame(16'h0199, 1'b1, 16, 1'b0, 1'b0, 1'b0, 1'b0, "R2 new pair");

        repeat (3) @(negedge clk);
        check("R5 all verdicts seen", q_acc.size() == 0, q_acc.size(), 0);
        finish_run();
    end

endmodule